// File: doc/BRIEF.md
# Programmable Precision Rounding Unit

This block takes a normalized, not yet rounded floating-point result and rounds it to a precision chosen at run time. The operand arrives as a sign, a biased exponent, a significand with an explicit integer bit, and two extra bits below the significand: a guard bit and a sticky bit that summarise what an earlier stage shifted out. A two-bit precision code selects how many significand bits survive: the full 64, 53 for double, or 24 for single. A two-bit mode code selects the rounding direction.

The result is registered one cycle after a valid input. Its significand has every bit below the kept width cleared. Its exponent is incremented when rounding carries out of the kept field. Two flags come with it: inexact reports that something was discarded, and overflow reports that the carry pushed the exponent to all ones. All datapath widths are parameters, so the same logic rounds at any three widths inside one significand register. When both control codes are zero, the result is rounded to nearest at full width. Only normalized inputs are handled; denormals and gradual underflow are not produced.

Top module: `prec_rounder`

## Requirements
- R1: Precision code 2'b01 keeps the top SGL_W (24) significand bits, 2'b10 keeps the top DBL_W (53), and 2'b00 and 2'b11 keep all SIG_W (64). Every output significand bit below the kept width is zero.
- R2: Mode 2'b00 rounds to nearest. The discarded part, including guard and sticky, is compared with one half unit of the kept LSB. An exact half rounds to the value whose kept LSB is 0.
- R3: Mode 2'b01 truncates: the kept bits pass unchanged and the exponent never changes.
- R4: Mode 2'b10 (toward minus infinity) adds one unit in the kept LSB exactly when the sign is 1 and the result is inexact.
- R5: Mode 2'b11 (toward plus infinity) adds one unit in the kept LSB exactly when the sign is 0 and the result is inexact.
- R6: When the increment carries out of the kept field, the significand becomes the MSB alone set, and the exponent is the input exponent plus one.
- R7: overflow_o is 1 exactly when a carry-out made the output exponent all ones; otherwise it is 0.
- R8: inexact_o is 1 exactly when any discarded significand bit, the guard bit or the sticky bit is 1. When it is 0, significand and exponent pass unchanged.
- R9: Outputs update on the clock edge that samples in_valid high, and out_valid follows in_valid by one cycle. Reset clears out_valid and all outputs to zero.
- R10: sign_o equals the input sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input operand is valid this cycle |
| sign_i | input | 1 | Operand sign |
| exp_i | input | EXP_W | Biased exponent |
| sig_i | input | SIG_W | Significand, explicit integer bit at MSB |
| guard_i | input | 1 | First bit below the significand |
| sticky_i | input | 1 | OR of all lower discarded bits |
| prec_i | input | 2 | Precision code |
| mode_i | input | 2 | Rounding direction code |
| out_valid | output | 1 | Result is valid |
| sign_o | output | 1 | Result sign |
| exp_o | output | EXP_W | Result exponent |
| sig_o | output | SIG_W | Rounded significand |
| inexact_o | output | 1 | A discarded bit was nonzero |
| overflow_o | output | 1 | Carry drove the exponent to all ones |

## Verification
The bench builds one instance with an 8-bit significand, a 3-bit exponent and kept widths of 3 and 5. In that size it can drive every normalized significand against every guard and sticky pair, both signs, all four precision codes and all four modes. At an exponent one below all ones, every carry-out also produces an overflow. A second instance keeps the default 64/24/53 widths and takes directed vectors: a single-precision tie that carries, a double-precision truncation, and a full-width carry into an all-ones exponent.

// File: rtl/prec_round_pkg.sv
package prec_round_pkg;
  typedef enum logic [1:0] {
    PREC_EXT  = 2'b00,
    PREC_SGL  = 2'b01,
    PREC_DBL  = 2'b10,
    PREC_EXT2 = 2'b11
  } prec_e;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_DOWN = 2'b10,
    RM_UP   = 2'b11
  } rmode_e;
endpackage

// File: rtl/rnd_mask_gen.sv
module rnd_mask_gen #(
  parameter int SIG_W = 64,
  parameter int SGL_W = 24,
  parameter int DBL_W = 53
) (
  input  logic [1:0]       prec,
  output logic [SIG_W-1:0] keep_mask,
  output logic [SIG_W-1:0] lsb_hot
);
  import prec_round_pkg::*;
  localparam int SGL_POS = SIG_W - SGL_W;
  localparam int DBL_POS = SIG_W - DBL_W;

  function automatic logic [SIG_W-1:0] ones_from(input int pos);
    return {SIG_W{1'b1}} << pos;
  endfunction

  function automatic logic [SIG_W-1:0] bit_at(input int pos);
    return {{(SIG_W-1){1'b0}}, 1'b1} << pos;
  endfunction

  int pos;
  always_comb begin
    case (prec)
      PREC_SGL: pos = SGL_POS;
      PREC_DBL: pos = DBL_POS;
      default:  pos = 0;
    endcase
    keep_mask = ones_from(pos);
    lsb_hot   = bit_at(pos);
  end

  // R1
  always_comb begin
    mask_onehot_chk: assert ($onehot0(lsb_hot));
  end
endmodule

// File: rtl/rnd_bits.sv
module rnd_bits #(
  parameter int SIG_W = 64
) (
  input  logic [SIG_W-1:0] sig,
  input  logic [SIG_W-1:0] keep_mask,
  input  logic [SIG_W-1:0] lsb_hot,
  input  logic             guard,
  input  logic             sticky,
  output logic             lsb_bit,
  output logic             round_bit,
  output logic             sticky_bit
);
  logic [SIG_W-1:0] below_hot;
  logic [SIG_W-1:0] rest_mask;

  always_comb begin
    below_hot = lsb_hot >> 1;
    rest_mask = ~keep_mask & ~below_hot;
    lsb_bit   = |(sig & lsb_hot);
    if (lsb_hot[0]) begin
      round_bit  = guard;
      sticky_bit = sticky;
    end else begin
      round_bit  = |(sig & below_hot);
      sticky_bit = (|(sig & rest_mask)) | guard | sticky;
    end
  end
endmodule

// File: rtl/rnd_decide.sv
module rnd_decide (
  input  logic [1:0] mode,
  input  logic       sign,
  input  logic       lsb_bit,
  input  logic       round_bit,
  input  logic       sticky_bit,
  output logic       inc,
  output logic       inexact
);
  import prec_round_pkg::*;

  always_comb begin
    inexact = round_bit | sticky_bit;
    case (mode)
      RM_NEAR: inc = round_bit & (sticky_bit | lsb_bit);
      RM_ZERO: inc = 1'b0;
      RM_DOWN: inc = sign & inexact;
      default: inc = ~sign & inexact;
    endcase
  end

  // R2: a tie with an even kept LSB must never round up
  always_comb begin
    if (mode == RM_NEAR && round_bit && !sticky_bit && !lsb_bit)
      tie_even_chk: assert (!inc);
  end
endmodule

// File: rtl/rnd_adjust.sv
module rnd_adjust #(
  parameter int SIG_W = 64,
  parameter int EXP_W = 15
) (
  input  logic [SIG_W-1:0] sig,
  input  logic [SIG_W-1:0] keep_mask,
  input  logic [SIG_W-1:0] lsb_hot,
  input  logic             inc,
  input  logic [EXP_W-1:0] exp_in,
  output logic [SIG_W-1:0] sig_out,
  output logic [EXP_W-1:0] exp_out,
  output logic             carry,
  output logic             ovf
);
  localparam logic [SIG_W-1:0] TOP_ONLY = {1'b1, {(SIG_W-1){1'b0}}};

  logic [SIG_W:0] sum;

  always_comb begin
    sum     = {1'b0, sig & keep_mask} + (inc ? {1'b0, lsb_hot} : '0);
    carry   = sum[SIG_W];
    sig_out = carry ? TOP_ONLY : sum[SIG_W-1:0];
    exp_out = exp_in + {{(EXP_W-1){1'b0}}, carry};
    ovf     = carry & (&exp_out);
  end

  // R6: a carry-out can only come from an increment
  always_comb begin
    if (carry) carry_inc_chk: assert (inc);
  end
endmodule

// File: rtl/prec_rounder.sv
module prec_rounder #(
  parameter int SIG_W = 64,
  parameter int EXP_W = 15,
  parameter int SGL_W = 24,
  parameter int DBL_W = 53
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             sign_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [SIG_W-1:0] sig_i,
  input  logic             guard_i,
  input  logic             sticky_i,
  input  logic [1:0]       prec_i,
  input  logic [1:0]       mode_i,
  output logic             out_valid,
  output logic             sign_o,
  output logic [EXP_W-1:0] exp_o,
  output logic [SIG_W-1:0] sig_o,
  output logic             inexact_o,
  output logic             overflow_o
);
  import prec_round_pkg::*;
  localparam int SGL_POS = SIG_W - SGL_W;
  localparam int DBL_POS = SIG_W - DBL_W;

  logic [SIG_W-1:0] keep_mask, lsb_hot, sig_rnd;
  logic [EXP_W-1:0] exp_rnd;
  logic lsb_bit, round_bit, sticky_bit, inc_w, inexact_w, carry_w, ovf_w;

  rnd_mask_gen #(.SIG_W(SIG_W), .SGL_W(SGL_W), .DBL_W(DBL_W)) u_mask (
    .prec(prec_i), .keep_mask(keep_mask), .lsb_hot(lsb_hot));

  rnd_bits #(.SIG_W(SIG_W)) u_bits (
    .sig(sig_i), .keep_mask(keep_mask), .lsb_hot(lsb_hot),
    .guard(guard_i), .sticky(sticky_i),
    .lsb_bit(lsb_bit), .round_bit(round_bit), .sticky_bit(sticky_bit));

  rnd_decide u_decide (
    .mode(mode_i), .sign(sign_i), .lsb_bit(lsb_bit), .round_bit(round_bit),
    .sticky_bit(sticky_bit), .inc(inc_w), .inexact(inexact_w));

  rnd_adjust #(.SIG_W(SIG_W), .EXP_W(EXP_W)) u_adjust (
    .sig(sig_i), .keep_mask(keep_mask), .lsb_hot(lsb_hot), .inc(inc_w),
    .exp_in(exp_i), .sig_out(sig_rnd), .exp_out(exp_rnd),
    .carry(carry_w), .ovf(ovf_w));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      sign_o     <= 1'b0;
      exp_o      <= '0;
      sig_o      <= '0;
      inexact_o  <= 1'b0;
      overflow_o <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        sign_o     <= sign_i;
        exp_o      <= exp_rnd;
        sig_o      <= sig_rnd;
        inexact_o  <= inexact_w;
        overflow_o <= ovf_w;
      end
    end
  end

  // R1
  sgl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(prec_i) == PREC_SGL |-> sig_o[SGL_POS-1:0] == '0);
  // R1
  dbl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(prec_i) == PREC_DBL |-> sig_o[DBL_POS-1:0] == '0);
  // R3
  rz_exp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(mode_i) == RM_ZERO |-> exp_o == $past(exp_i) && !overflow_o);
  // R7
  ovf_all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |-> &exp_o);
  // R8
  exact_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !inexact_o |-> sig_o == $past(sig_i) && exp_o == $past(exp_i));
  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid) |-> out_valid);
  // R10
  sign_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> sign_o == $past(sign_i));
endmodule

// File: tb/prec_rounder_bench.sv
module prec_rounder_bench;
  localparam int SW = 8, EW = 3, S1 = 3, D1 = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  logic in_valid = 1'b0, sign_i = 1'b0, guard_i = 1'b0, sticky_i = 1'b0;
  logic [EW-1:0] exp_i = '0;
  logic [SW-1:0] sig_i = '0;
  logic [1:0] prec_i = '0, mode_i = '0;
  logic out_valid, sign_o, inexact_o, overflow_o;
  logic [EW-1:0] exp_o;
  logic [SW-1:0] sig_o;

  prec_rounder #(.SIG_W(SW), .EXP_W(EW), .SGL_W(S1), .DBL_W(D1)) u_prec_rounder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sign_i(sign_i),
    .exp_i(exp_i), .sig_i(sig_i), .guard_i(guard_i), .sticky_i(sticky_i),
    .prec_i(prec_i), .mode_i(mode_i), .out_valid(out_valid), .sign_o(sign_o),
    .exp_o(exp_o), .sig_o(sig_o), .inexact_o(inexact_o), .overflow_o(overflow_o));

  logic f_valid = 1'b0, f_sign = 1'b0, f_guard = 1'b0, f_sticky = 1'b0;
  logic [14:0] f_exp = '0;
  logic [63:0] f_sig = '0;
  logic [1:0] f_prec = '0, f_mode = '0;
  logic f_ovalid, f_osign, f_inx, f_ovf;
  logic [14:0] f_oexp;
  logic [63:0] f_osig;

  prec_rounder u_prec_rounder_full (
    .clk(clk), .rst_n(rst_n), .in_valid(f_valid), .sign_i(f_sign),
    .exp_i(f_exp), .sig_i(f_sig), .guard_i(f_guard), .sticky_i(f_sticky),
    .prec_i(f_prec), .mode_i(f_mode), .out_valid(f_ovalid), .sign_o(f_osign),
    .exp_o(f_oexp), .sig_o(f_osig), .inexact_o(f_inx), .overflow_o(f_ovf));

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  // Reference: discarded part scaled so that half a kept LSB is 1 << (p+1)
  task automatic ref_round(input int s, input int e, input int sg, input int g,
                           input int st, input int pr, input int md,
                           output int o_sig, output int o_exp,
                           output int o_inx, output int o_ovf, output int o_carry);
    int w, p, keep, frac, half, inc;
    w = (pr == 1) ? S1 : (pr == 2) ? D1 : SW;
    p = SW - w;
    keep = sg >> p;
    frac = ((sg & ((1 << p) - 1)) << 2) | (g << 1) | st;
    half = 1 << (p + 1);
    o_inx = (frac != 0);
    case (md)
      0: inc = (frac > half) || (frac == half && (keep % 2) == 1);
      1: inc = 0;
      2: inc = (s == 1) && o_inx;
      default: inc = (s == 0) && o_inx;
    endcase
    keep = keep + inc;
    o_exp = e; o_ovf = 0; o_carry = 0;
    if (keep == (1 << w)) begin
      keep = 1 << (w - 1);
      o_exp = e + 1;
      o_carry = 1;
      o_ovf = (o_exp == (1 << EW) - 1);
    end
    o_sig = keep << p;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    report();
  end

  initial begin
    int es, ee, ei, eo, ec;
    string tag;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(out_valid == 0 && sig_o == 0 && exp_o == 0 && !inexact_o && !overflow_o && !sign_o,
          "R9", "reset outputs", {out_valid, sig_o, exp_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int sg = 128; sg < 256; sg++)
      for (int gs = 0; gs < 4; gs++)
        for (int s = 0; s < 2; s++)
          for (int pr = 0; pr < 4; pr++)
            for (int md = 0; md < 4; md++)
              for (int ex = 0; ex < 2; ex++) begin
                int e;
                e = ex ? 6 : 1;
                in_valid = 1'b1; sign_i = s[0]; exp_i = e[EW-1:0]; sig_i = sg[SW-1:0];
                guard_i = gs[1]; sticky_i = gs[0]; prec_i = pr[1:0]; mode_i = md[1:0];
                @(negedge clk);
                ref_round(s, e, sg, gs / 2, gs % 2, pr, md, es, ee, ei, eo, ec);
                tag = (ec != 0) ? "R6" : (md == 0) ? "R2" : (md == 1) ? "R3" :
                      (md == 2) ? "R4" : "R5";
                check(out_valid == 1, "R9", "out_valid", out_valid, 1);
                check(sig_o == es[SW-1:0], tag, "significand", sig_o, es);
                check(exp_o == ee[EW-1:0], (ec != 0) ? "R6" : "R3", "exponent", exp_o, ee);
                check(inexact_o == ei[0], "R8", "inexact", inexact_o, ei);
                check(overflow_o == eo[0], "R7", "overflow", overflow_o, eo);
                check(sign_o == s[0], "R10", "sign", sign_o, s);
                if (pr == 1) check(sig_o[SW-S1-1:0] == 0, "R1", "single low bits", sig_o, es);
                if (pr == 2) check(sig_o[SW-D1-1:0] == 0, "R1", "double low bits", sig_o, es);
              end
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 0, "R9", "valid drops", out_valid, 0);

    // Full-width directed: single-precision tie with odd LSB carries (R2, R6)
    f_valid = 1; f_sign = 0; f_exp = 15'd16383; f_sig = 64'hFFFF_FF80_0000_0000;
    f_guard = 0; f_sticky = 0; f_prec = 2'b01; f_mode = 2'b00;
    @(negedge clk);
    check(f_osig == 64'h8000_0000_0000_0000, "R6", "full sgl tie sig", f_osig, 64'h8000_0000_0000_0000);
    check(f_oexp == 15'd16384, "R6", "full sgl tie exp", f_oexp, 16384);
    check(f_inx == 1 && f_ovf == 0, "R8", "full sgl tie flags", {f_inx, f_ovf}, 2);
    // Double precision truncation (R1, R3)
    f_sig = 64'hFFFF_FFFF_FFFF_FFFF; f_guard = 1; f_prec = 2'b10; f_mode = 2'b01;
    @(negedge clk);
    check(f_osig == 64'hFFFF_FFFF_FFFF_F800, "R1", "full dbl trunc sig", f_osig, 64'hFFFF_FFFF_FFFF_F800);
    check(f_oexp == 15'd16383, "R3", "full dbl trunc exp", f_oexp, 16383);
    // Extended, toward plus infinity, carry into all-ones exponent (R5, R7)
    f_exp = 15'h7FFE; f_guard = 0; f_sticky = 1; f_prec = 2'b11; f_mode = 2'b11;
    @(negedge clk);
    check(f_osig == 64'h8000_0000_0000_0000, "R5", "full ext up sig", f_osig, 64'h8000_0000_0000_0000);
    check(f_oexp == 15'h7FFF && f_ovf == 1, "R7", "full ext overflow", {f_oexp, f_ovf}, 16'hFFFF);
    f_valid = 0;
    @(negedge clk);
    report();
  end
endmodule